// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame enters the receive FIFO. It holds an eight-byte bank of acceptance codes and a matching eight-byte bank of masks. A two-bit mode field splits the bank into two 32-bit filters, four 16-bit filters or eight 8-bit filters, or shuts it completely. When the deserialiser signals that a frame is complete, every filter compares its share of the identifier bytes against its code bytes at the same moment. If any filter hits, the block pulses `accept` and records the number of the lowest-numbered filter that hit.

The recorded number waits in a small side queue that is as deep as the receive FIFO. It appears on `hit_idx` only when the FIFO reports, through `fg_shift`, that this frame has moved into the foreground slot. The output therefore always describes the message software is reading at that moment. A byte-wide register port reaches the mode, code and mask registers. Reads are allowed at any time. Writes take effect only while the initialisation request and the initialisation acknowledge are both high.

Top module: `can_id_filter`

## Requirements
- R1: Mode field encoding (control register, address 0, bits 1:0): 00 gives two 32-bit filters, 01 gives four 16-bit filters, 10 gives eight 8-bit filters, and 11 shuts the filter.
- R2: Code byte k is at address 8+k and mask byte k is at address 16+k (k = 0..7). A mask bit of 1 makes that bit don't-care. A filter hits only when every unmasked bit of its code bytes equals the matching identifier bit.
- R3: Identifier byte j is `rx_id[8j+7:8j]`. In 32-bit mode, filter f compares code bytes 4f..4f+3 with identifier bytes 0..3. In 16-bit mode, filter f compares code bytes 2f..2f+1 with identifier bytes 0..1. In 8-bit mode, filter f compares code byte f with identifier byte 0.
- R4: When several filters hit, the lowest-numbered one wins. Its number is recorded as a 3-bit binary value (000 = filter 0 up to 111 = filter 7).
- R5: `accept` is high for exactly the one cycle after a cycle in which `rx_done` was high and at least one filter hit.
- R6: In shut mode no frame is accepted, no index is queued and `hit_idx` does not change.
- R7: `hit_idx` changes only on a cycle with `fg_shift` high. It then takes the oldest queued index. If the queue is empty and a frame is accepted in that same cycle, it takes that frame's index directly. If the queue is empty and no frame is accepted, it holds its value.
- R8: Mode, code and mask writes take effect only when `init_req` and `init_ack` are both high. `reg_rdata` always shows the addressed register combinationally. Unmapped addresses read as 0.
- R9: The control register reads as {0, hit_idx[2:0], 00, mode[1:0]}. Its hit bits are read-only, and writes to them are ignored.
- R10: After reset the mode is 00, all codes and masks are 0 (every bit is compared), `hit_idx` is 000 and `accept` is low.
- R11: The side queue holds QDEPTH (default 4) indexes. An index accepted while the queue is full and no shift is happening is dropped. `accept` still pulses for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Initialisation request |
| init_ack | input | 1 | Initialisation acknowledge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rx_id | input | 32 | Identifier bytes of the received frame |
| rx_done | input | 1 | Frame-complete strobe |
| fg_shift | input | 1 | FIFO moved a new message into the foreground slot |
| accept | output | 1 | Frame accepted (one-cycle pulse) |
| hit_idx | output | 3 | Hit filter number of the foreground message |

## Verification
Two events can land on the same clock edge: a completed frame that gets accepted and pushes its index, and a foreground shift that pops an index. The bench drives `rx_done` and `fg_shift` high together in two situations. With an empty queue, the new index must go straight to `hit_idx`. With a queued entry, the older index must be shown while the new one is appended. It then fills the queue to its limit and drains it to see the drop. A behavioural model built on a queue predicts `accept`, `hit_idx` and the read data after every edge. This also covers random runs in which writes, the lock, frames and shifts collide.

// File: rtl/can_filt_pkg.sv
// Shared constants and types for the CAN identifier acceptance filter.
// Assumes a fixed eight-byte filter bank and four identifier bytes per frame.
package can_filt_pkg;
    typedef enum logic [1:0] {
        MODE_W32  = 2'b00,
        MODE_W16  = 2'b01,
        MODE_W8   = 2'b10,
        MODE_SHUT = 2'b11
    } filt_mode_e;

    localparam int BANK_BYTES = 8;
    localparam int ID_BYTES   = 4;
    localparam int ID_W       = ID_BYTES * 8;
    localparam int BANK_W     = BANK_BYTES * 8;
    localparam int HIT_W      = 3;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int CTRL_ADDR  = 0;
    localparam int CODE_BASE  = 8;
    localparam int MASK_BASE  = 16;
endpackage

// File: rtl/can_filt_regs.sv
// Register bank: mode, code and mask registers behind a byte-wide port.
// Writes land only while wr_open is high. Reads are combinational.
// Assumes the hit index is supplied from outside and is read-only here.
module can_filt_regs
    import can_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_open,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [HIT_W-1:0]  hit_idx,
    output filt_mode_e        mode,
    output logic [BANK_W-1:0] code_bank,
    output logic [BANK_W-1:0] mask_bank,
    output logic [DATA_W-1:0] reg_rdata
);
    // Store the registers, gated by the initialisation lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MODE_W32;
            code_bank <= '0;
            mask_bank <= '0;
        end else if (reg_we && wr_open) begin
            if (reg_addr == ADDR_W'(CTRL_ADDR))
                mode <= filt_mode_e'(reg_wdata[1:0]);
            for (int i = 0; i < BANK_BYTES; i++) begin
                if (reg_addr == ADDR_W'(CODE_BASE + i))
                    code_bank[i*8 +: 8] <= reg_wdata;
                if (reg_addr == ADDR_W'(MASK_BASE + i))
                    mask_bank[i*8 +: 8] <= reg_wdata;
            end
        end
    end

    // Return the addressed register; unmapped addresses read as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(CTRL_ADDR))
            reg_rdata = {1'b0, hit_idx, 2'b00, mode};
        for (int i = 0; i < BANK_BYTES; i++) begin
            if (reg_addr == ADDR_W'(CODE_BASE + i))
                reg_rdata = code_bank[i*8 +: 8];
            if (reg_addr == ADDR_W'(MASK_BASE + i))
                reg_rdata = mask_bank[i*8 +: 8];
        end
    end
endmodule

// File: rtl/can_filt_match.sv
// Combinational matcher: masked byte compares, grouped by mode into filters,
// then a lowest-index-wins priority encoder.
// Assumes mask bit 1 means don't-care and that shut mode yields no hit.
module can_filt_match
    import can_filt_pkg::*;
(
    input  filt_mode_e        mode,
    input  logic [BANK_W-1:0] code_bank,
    input  logic [BANK_W-1:0] mask_bank,
    input  logic [ID_W-1:0]   rx_id,
    output logic              any_hit,
    output logic [HIT_W-1:0]  hit_num
);
    logic [BANK_BYTES-1:0] byte_ok;
    logic [BANK_BYTES-1:0] filt_hit;

    // One masked comparator per bank byte; the identifier byte it sees depends on the mode.
    for (genvar g = 0; g < BANK_BYTES; g++) begin : g_byte
        localparam int S32 = g % 4;
        localparam int S16 = g % 2;
        logic [7:0] id_sel;
        assign id_sel = (mode == MODE_W32) ? rx_id[S32*8 +: 8] :
                        (mode == MODE_W16) ? rx_id[S16*8 +: 8] : rx_id[7:0];
        assign byte_ok[g] = ((code_bank[g*8 +: 8] ^ id_sel) & ~mask_bank[g*8 +: 8]) == 8'h00;
    end

    // Combine byte results into per-filter hits according to the mode.
    always_comb begin
        unique case (mode)
            MODE_W32: filt_hit = {6'b0, &byte_ok[7:4], &byte_ok[3:0]};
            MODE_W16: filt_hit = {4'b0, &byte_ok[7:6], &byte_ok[5:4],
                                  &byte_ok[3:2], &byte_ok[1:0]};
            MODE_W8:  filt_hit = byte_ok;
            default:  filt_hit = '0;
        endcase
    end

    // Lowest-numbered hitting filter wins.
    always_comb begin
        hit_num = '0;
        for (int i = BANK_BYTES - 1; i >= 0; i--)
            if (filt_hit[i]) hit_num = HIT_W'(i);
    end

    assign any_hit = |filt_hit;
endmodule

// File: rtl/can_filt_hitq.sv
// Side queue of hit indexes for accepted frames, plus the foreground register.
// A shift pops the oldest index into the foreground. With an empty queue, an
// index pushed in the same cycle bypasses the queue. A push into a full queue
// without a pop is dropped.
module can_filt_hitq
    import can_filt_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [HIT_W-1:0] push_idx,
    input  logic             shift,
    output logic [HIT_W-1:0] fg_idx
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [HIT_W-1:0] store [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic empty, full, pop, bypass, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop     = shift && !empty;
    assign bypass  = shift && empty && push;
    assign do_push = push && !bypass && (!full || pop);

    // Write queued indexes into the storage array.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_ptr] <= push_idx;
    end

    // Move the pointers, the occupancy count and the foreground index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            fg_idx <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
                fg_idx <= store[rd_ptr];
            end else if (bypass) begin
                fg_idx <= push_idx;
            end
            case ({do_push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/can_id_filter.sv
// Top of the CAN identifier acceptance filter.
// Assumes rx_id is stable in the cycle rx_done is high. fg_shift comes from
// the receive FIFO when a new message reaches its foreground slot.
module can_id_filter
    import can_filt_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              init_ack,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ID_W-1:0]   rx_id,
    input  logic              rx_done,
    input  logic              fg_shift,
    output logic              accept,
    output logic [HIT_W-1:0]  hit_idx
);
    filt_mode_e        mode_q;
    logic [BANK_W-1:0] code_bank, mask_bank;
    logic              any_hit, take;
    logic [HIT_W-1:0]  hit_num;

    can_filt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_open   (init_req && init_ack),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .hit_idx   (hit_idx),
        .mode      (mode_q),
        .code_bank (code_bank),
        .mask_bank (mask_bank),
        .reg_rdata (reg_rdata)
    );

    can_filt_match u_match (
        .mode      (mode_q),
        .code_bank (code_bank),
        .mask_bank (mask_bank),
        .rx_id     (rx_id),
        .any_hit   (any_hit),
        .hit_num   (hit_num)
    );

    assign take = rx_done && any_hit;

    can_filt_hitq #(.DEPTH(QDEPTH)) u_hitq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .push_idx (hit_num),
        .shift    (fg_shift),
        .fg_idx   (hit_idx)
    );

    // Register the one-cycle accept pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) accept <= 1'b0;
        else        accept <= take;
    end
endmodule

// File: rtl/can_filt_chk.sv
// Checker for the acceptance filter, attached to the top by bind.
// Observes ports and the stored mode only.
module can_filt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       init_req,
    input logic       init_ack,
    input logic       rx_done,
    input logic       fg_shift,
    input logic       accept,
    input logic [2:0] hit_idx,
    input logic [1:0] mode
);
    // R5
    accept_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(rx_done));

    // R6
    shut_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && mode == 2'b11) |=> !accept);

    // R7
    hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fg_shift |=> $stable(hit_idx));

    // R8
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_req && init_ack) |=> $stable(mode));
endmodule

bind can_id_filter can_filt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .init_ack (init_ack),
    .rx_done  (rx_done),
    .fg_shift (fg_shift),
    .accept   (accept),
    .hit_idx  (hit_idx),
    .mode     (mode_q)
);

// File: tb/sim_can_id_filter.sv
`timescale 1ns/1ps
module sim_can_id_filter;
    localparam int QD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0, init_ack = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [31:0] rx_id = '0;
    logic        rx_done = 1'b0, fg_shift = 1'b0;
    logic        accept;
    logic [2:0]  hit_idx;

    always #4 clk = ~clk;

    can_id_filter #(.QDEPTH(QD)) u0 (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_ack(init_ack),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_id(rx_id), .rx_done(rx_done),
        .fg_shift(fg_shift), .accept(accept), .hit_idx(hit_idx)
    );

    // Behavioural reference state
    int         m_mode;
    logic [7:0] m_code [8];
    logic [7:0] m_mask [8];
    int         m_q [$];
    int         m_hit;
    bit         m_acc;
    int         checks = 0, fails = 0;
    string      cur_req = "R10";
    bit         done = 0;

    function automatic int model_match(logic [31:0] id);
        int nf, w;
        if (m_mode == 3) return -1;
        nf = (m_mode == 0) ? 2 : (m_mode == 1) ? 4 : 8;
        w  = 8 / nf;
        for (int f = 0; f < nf; f++) begin
            bit ok = 1;
            for (int b = 0; b < w; b++) begin
                logic [7:0] idb = id[b*8 +: 8];
                if (((m_code[f*w+b] ^ idb) & ~m_mask[f*w+b]) != 8'h00) ok = 0;
            end
            if (ok) return f;
        end
        return -1;
    endfunction

    function automatic logic [7:0] model_read(logic [4:0] a);
        if (a == 0) return {1'b0, 3'(m_hit), 2'b00, 2'(m_mode)};
        if (a >= 8 && a < 16) return m_code[a-8];
        if (a >= 16 && a < 24) return m_mask[a-16];
        return 8'h00;
    endfunction

    task automatic model_reset();
        m_mode = 0; m_hit = 0; m_acc = 0; m_q.delete();
        for (int i = 0; i < 8; i++) begin m_code[i] = 0; m_mask[i] = 0; end
    endtask

    task automatic check(bit ok, string what, int got, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got %0h exp %0h", cur_req, what, got, exp);
        end
    endtask

    // One clock: drive, advance the model on the edge, then compare.
    task automatic step(bit we, logic [4:0] a, logic [7:0] d, bit rxd, logic [31:0] id, bit fg);
        int h;
        bit push;
        reg_we = we; reg_addr = a; reg_wdata = d; rx_done = rxd; rx_id = id; fg_shift = fg;
        @(posedge clk);
        h = model_match(id);
        push = rxd && (h >= 0);
        m_acc = push;
        if (fg) begin
            if (m_q.size() > 0) begin
                m_hit = m_q.pop_front();
                if (push) m_q.push_back(h);
            end else if (push) m_hit = h;
        end else if (push && m_q.size() < QD) m_q.push_back(h);
        if (we && init_req && init_ack) begin
            if (a == 0) m_mode = int'(d[1:0]);
            else if (a >= 8 && a < 16) m_code[a-8] = d;
            else if (a >= 16 && a < 24) m_mask[a-16] = d;
        end
        #2;
        check(accept === m_acc, "accept", accept, m_acc);
        check(hit_idx === 3'(m_hit), "hit_idx", hit_idx, m_hit);
        check(reg_rdata === model_read(reg_addr), "rdata", reg_rdata, model_read(reg_addr));
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d); step(1, a, d, 0, 0, 0); endtask
    task automatic rd(logic [4:0] a);                step(0, a, 0, 0, 0, 0); endtask
    task automatic frame(logic [31:0] id);           step(0, 0, 0, 1, id, 0); endtask
    task automatic shift();                          step(0, 0, 0, 0, 0, 1); endtask

    initial begin
        model_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R10: reset values of control, a code and a mask register
        cur_req = "R10"; rd(0); rd(8); rd(16); rd(23);
        // R8: writes locked unless both init_req and init_ack are high
        cur_req = "R8"; wr(0, 8'h02); rd(0); wr(8, 8'h12); rd(8);
        init_req = 1; wr(0, 8'h02); rd(0);
        init_req = 0; init_ack = 1; wr(17, 8'h55); rd(17); rd(30);
        init_req = 1;
        // R1 R2 R3: 32-bit filters
        cur_req = "R1 R2 R3";
        wr(8, 8'h12); wr(9, 8'h34); wr(10, 8'h56); wr(11, 8'h78);
        wr(12, 8'h11); wr(13, 8'h22); wr(14, 8'h33); wr(15, 8'h44);
        frame(32'h78563412); shift();
        frame(32'h79563412); rd(0);
        wr(19, 8'hFF); frame(32'h79563412); shift();
        frame(32'h44332211); shift(); rd(0);
        // R3: 16-bit filters use identifier bytes 0..1
        cur_req = "R3"; wr(0, 8'h01);
        frame(32'hFFFF7856); shift(); frame(32'h00003412); shift();
        // R4: 8-bit filters, fully masked filter 3 beats filter 4
        cur_req = "R4"; wr(0, 8'h02);
        frame(32'h00000011); shift();
        wr(19, 8'h00); frame(32'h00000011); shift(); frame(32'h00000099); rd(0);
        // R9: hit bits in the control register are read-only
        cur_req = "R9"; wr(0, 8'h71); rd(0);
        // R6: shut mode accepts nothing and holds hit_idx
        cur_req = "R6"; wr(0, 8'h03); frame(32'h78563412); shift(); rd(0);
        // R7: frame completion and foreground shift in the same cycle
        cur_req = "R7"; wr(0, 8'h00);
        frame(32'h44332211); shift();
        step(0, 0, 0, 1, 32'h78563412, 1);
        frame(32'h44332211); step(0, 0, 0, 1, 32'h78563412, 1); shift(); shift();
        // R11: queue overflow drops the fifth index
        cur_req = "R11";
        frame(32'h78563412); frame(32'h44332211); frame(32'h78563412);
        frame(32'h44332211); frame(32'h78563412);
        repeat (6) shift();
        // R2 R4 R5 R7: randomised mixing of writes, lock, frames and shifts
        cur_req = "R2 R4 R5 R7";
        for (int n = 0; n < 600; n++) begin
            logic [31:0] id;
            logic [4:0]  a;
            int sel = $urandom_range(0, 3);
            init_req = ($urandom_range(0, 3) != 0);
            init_ack = ($urandom_range(0, 3) != 0);
            a = (sel == 0) ? 5'd0 : (sel == 1) ? 5'(8 + $urandom_range(0, 7)) :
                (sel == 2) ? 5'(16 + $urandom_range(0, 7)) : 5'd30;
            for (int b = 0; b < 4; b++) begin
                int k = $urandom_range(0, 3);
                id[b*8 +: 8] = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : (k == 2) ? 8'hA5 : 8'hFF;
            end
            step($urandom_range(0, 3) == 0, a,
                 ($urandom_range(0, 1) == 0) ? 8'(5'h0 + $urandom_range(0, 3)) : 8'($urandom_range(0, 255)),
                 $urandom_range(0, 1) == 1, id, $urandom_range(0, 2) == 0);
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog got 1 exp 0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule